// File: doc/BRIEF.md
# CRC32 Register Engine

This block computes a 32-bit cyclic redundancy check over a stream of 32-bit words under register control. Software programs a generator polynomial and a seed, loads a word count (directly or through a reload value), then sets the enable bit with the stream mode selected. Words are fed either by writes to a FIFO register or through a valid/ready word port. Each word can be mirrored (bits inside bytes, byte order, halfword order) before it updates the running value.

When the last counted word has been folded in, the engine latches the final result, raises an expiry event, compares the result with a compare register and raises a mismatch event if they differ. Both events are write-1-to-clear status bits and can each drive the single interrupt output through an enable register that has its own set and clear aliases. After every polynomial write the engine spends a fixed preparation period before it consumes data again.

Registers are selected by a 4-bit word index: 0 control, 1 polynomial, 2 running value (write seeds it), 3 word count, 4 count reload, 5 count capture (read only), 6 compare, 7 FIFO input (write only), 8 status, 9 interrupt enable, 10 enable set, 11 enable clear, 12 final result (read only), 13 revision (read only). Unlisted indices read as zero and ignore writes.

Top module: `crc_regeng`

## Requirements
- R1: After reset the status register (index 8) reads 0x000D0000 (bits 16, 18 and 19 set, FIFO level 0), the interrupt output is low and the revision register reads the REVISION parameter.
- R2: With control bit 0 set and control bits 7:4 equal to 3, each FIFO word updates the running value MSB-first with the effective polynomial (no input or output inversion, no final XOR); writing index 2 loads the running value, reading index 2 returns it.
- R3: Control bit 16 reverses the bits inside each byte of an input word, bit 17 reverses its byte order, bit 18 swaps its 16-bit halves, applied in that order.
- R4: With control bit 19 set the input mirroring uses the control value present when the word enters the FIFO; with it clear it uses the control value present when the word is consumed.
- R5: Control bit 21 makes the engine use the bit-reversed polynomial register, bit 20 makes index 12 read the bit-reversed final result, bit 22 makes the comparison use the bit-reversed compare register.
- R6: Each consumed word decrements the count (index 3); the word that brings it to zero latches the final result, sets status bit 4 and copies the count loaded at enable into index 5; no word is consumed while the count is zero.
- R7: A rising edge of control bit 0 loads the count from the reload register (index 4) unless the count was written directly since the previous rising edge, in which case the written value is kept.
- R8: At expiry, status bit 1 is set when the final result differs from the effective compare value, and stays clear otherwise.
- R9: A polynomial write clears status bit 19 for 8 cycles, during which no FIFO word is consumed.
- R10: The FIFO holds 4 words; status bits 22:20 give its level, bit 16 is set while it is not full, and FIFO writes while full are discarded.
- R11: The stream port accepts a word when s_valid and s_ready are high; s_ready is low while the FIFO is full or a register FIFO write happens in the same cycle.
- R12: Interrupt enable bit 1 (compare error) and bit 4 (expiry) are set by writing 1s to index 10 and cleared by writing 1s to index 11; irq is high while an enabled event bit is set; writing 1 to an event bit of index 8 clears it.
- R13: With any mode other than 3 in bits 7:4 the enabled engine consumes no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Stream word accepted when high with s_valid |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 4-word FIFO, 8 preparation cycles and a 32-bit datapath. At that size all eight input-mirroring combinations can be swept against both polynomial orientations and one to three word jobs, with result and compare mirroring toggled across the sweep, while the shallow FIFO lets full-queue dropping, the preparation stall and the reload/direct-count interplay be reached with a handful of words. Expected values come from a bit-serial model of the requirements inside the bench.

// File: rtl/crc_regeng_pkg.sv
package crc_regeng_pkg;

    localparam int DW      = 32;
    localparam int REG_AW  = 4;

    localparam int ST_CMP   = 1;
    localparam int ST_EXP   = 4;
    localparam int ST_INRDY = 16;
    localparam int ST_OUTRDY = 17;
    localparam int ST_IDLE  = 18;
    localparam int ST_TBL   = 19;
    localparam int ST_LVL   = 20;

    localparam logic [3:0] MODE_STREAM = 4'd3;

    typedef enum logic [REG_AW-1:0] {
        RG_CTRL     = 4'd0,
        RG_POLY     = 4'd1,
        RG_RUN      = 4'd2,
        RG_COUNT    = 4'd3,
        RG_RELOAD   = 4'd4,
        RG_CAPTURE  = 4'd5,
        RG_CMP      = 4'd6,
        RG_FIFO     = 4'd7,
        RG_STATUS   = 4'd8,
        RG_IEN      = 4'd9,
        RG_IEN_SET  = 4'd10,
        RG_IEN_CLR  = 4'd11,
        RG_RESULT   = 4'd12,
        RG_REV      = 4'd13
    } reg_e;

    typedef struct packed {
        logic [8:0] rsv_hi;
        logic       cmp_mir;
        logic       poly_mir;
        logic       res_mir;
        logic       mir_first;
        logic       half_swap;
        logic       byte_rev;
        logic       bit_rev;
        logic [7:0] rsv_mid;
        logic [3:0] mode;
        logic [2:0] rsv_lo;
        logic       enable;
    } ctrl_t;

    function automatic logic [DW-1:0] rev32(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
        return r;
    endfunction

    function automatic logic [DW-1:0] mirror_in(input logic [DW-1:0] v, input ctrl_t c);
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        for (int i = 0; i < DW; i++) a[i] = c.bit_rev ? v[(i & ~7) + 7 - (i & 7)] : v[i];
        for (int k = 0; k < DW/8; k++) b[8*k +: 8] = c.byte_rev ? a[8*(DW/8-1-k) +: 8] : a[8*k +: 8];
        return c.half_swap ? {b[DW/2-1:0], b[DW-1:DW/2]} : b;
    endfunction

    function automatic logic [DW-1:0] crc_word(input logic [DW-1:0] crc,
                                               input logic [DW-1:0] data,
                                               input logic [DW-1:0] poly);
        logic [DW-1:0] c;
        logic          fb;
        c = crc;
        for (int i = DW-1; i >= 0; i--) begin
            fb = c[DW-1] ^ data[i];
            c  = {c[DW-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_regeng_fifo.sv
module crc_regeng_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [W-1:0]    din,
    input  logic            pop,
    output logic [W-1:0]    dout,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (level == LVLW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            level <= level + LVLW'(do_push) - LVLW'(do_pop);
        end
    end
endmodule

// File: rtl/crc_regeng_core.sv
module crc_regeng_core
    import crc_regeng_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          seed_we,
    input  logic [DW-1:0] seed,
    input  logic          step,
    input  logic [DW-1:0] word,
    input  logic [DW-1:0] poly,
    output logic [DW-1:0] crc,
    output logic [DW-1:0] crc_nxt
);
    assign crc_nxt = crc_word(crc, word, poly);

    always_ff @(posedge clk) begin
        if (rst)          crc <= '0;
        else if (seed_we) crc <= seed;
        else if (step)    crc <= crc_nxt;
    end
endmodule

// File: rtl/crc_regeng.sv
module crc_regeng
    import crc_regeng_pkg::*;
#(
    parameter int          FIFO_DEPTH  = 4,
    parameter int          TBL_CYCLES  = 8,
    parameter logic [31:0] REVISION    = 32'h0001_0300,
    parameter logic [31:0] POLY_RESET  = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              s_valid,
    input  logic [31:0]       s_data,
    output logic              s_ready,
    output logic              irq
);
    localparam int LVLW = $clog2(FIFO_DEPTH + 1);
    localparam int TW   = $clog2(TBL_CYCLES + 1);

    ctrl_t           ctrl_q;
    logic [DW-1:0]   poly_q, cmp_q, cnt_q, reload_q, loaded_q, capture_q, result_q;
    logic            cnt_wr_q, res_valid_q;
    logic [1:0]      evt_q, ien_q;
    logic [TW-1:0]   tbl_cnt;

    logic wr_ctrl, wr_poly, wr_run, wr_cnt, wr_reload, wr_cmp, wr_fifo;
    logic wr_status, wr_ien, wr_ien_set, wr_ien_clr;
    logic en_rise, tbl_done, fifo_pop, fifo_push, expire, mismatch;
    logic fifo_full, fifo_empty;
    logic [LVLW-1:0] fifo_level;
    logic [DW-1:0]   push_raw, push_word, fifo_dout, core_word;
    logic [DW-1:0]   eff_poly, eff_cmp, crc_run, crc_nxt;
    logic [1:0]      evt_set, evt_clr;

    assign wr_ctrl    = reg_wr && (reg_addr == RG_CTRL);
    assign wr_poly    = reg_wr && (reg_addr == RG_POLY);
    assign wr_run     = reg_wr && (reg_addr == RG_RUN);
    assign wr_cnt     = reg_wr && (reg_addr == RG_COUNT);
    assign wr_reload  = reg_wr && (reg_addr == RG_RELOAD);
    assign wr_cmp     = reg_wr && (reg_addr == RG_CMP);
    assign wr_fifo    = reg_wr && (reg_addr == RG_FIFO);
    assign wr_status  = reg_wr && (reg_addr == RG_STATUS);
    assign wr_ien     = reg_wr && (reg_addr == RG_IEN);
    assign wr_ien_set = reg_wr && (reg_addr == RG_IEN_SET);
    assign wr_ien_clr = reg_wr && (reg_addr == RG_IEN_CLR);

    assign en_rise  = wr_ctrl && reg_wdata[0] && !ctrl_q.enable;
    assign tbl_done = (tbl_cnt == '0);

    // Input path: register writes win over the stream port
    assign s_ready   = !fifo_full && !wr_fifo;
    assign fifo_push = wr_fifo || (s_valid && s_ready);
    assign push_raw  = wr_fifo ? reg_wdata : s_data;
    assign push_word = ctrl_q.mir_first ? mirror_in(push_raw, ctrl_q) : push_raw;

    assign fifo_pop = ctrl_q.enable && (ctrl_q.mode == MODE_STREAM) && tbl_done
                      && !fifo_empty && (cnt_q != '0);
    assign core_word = ctrl_q.mir_first ? fifo_dout : mirror_in(fifo_dout, ctrl_q);

    assign eff_poly = ctrl_q.poly_mir ? rev32(poly_q) : poly_q;
    assign eff_cmp  = ctrl_q.cmp_mir  ? rev32(cmp_q)  : cmp_q;
    assign expire   = fifo_pop && (cnt_q == 32'd1);
    assign mismatch = (crc_nxt != eff_cmp);

    crc_regeng_fifo #(.DEPTH(FIFO_DEPTH), .W(DW), .LVLW(LVLW)) u_fifo (
        .clk(clk), .rst(rst), .push(fifo_push), .din(push_word),
        .pop(fifo_pop), .dout(fifo_dout), .level(fifo_level),
        .full(fifo_full), .empty(fifo_empty)
    );

    crc_regeng_core u_core (
        .clk(clk), .rst(rst), .seed_we(wr_run), .seed(reg_wdata),
        .step(fifo_pop), .word(core_word), .poly(eff_poly),
        .crc(crc_run), .crc_nxt(crc_nxt)
    );

    assign evt_set = expire ? {1'b1, mismatch} : 2'b00;
    assign evt_clr = wr_status ? {reg_wdata[ST_EXP], reg_wdata[ST_CMP]} : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            poly_q      <= POLY_RESET;
            cmp_q       <= '0;
            cnt_q       <= '0;
            reload_q    <= '0;
            loaded_q    <= '0;
            capture_q   <= '0;
            result_q    <= '0;
            cnt_wr_q    <= 1'b0;
            res_valid_q <= 1'b0;
            evt_q       <= '0;
            ien_q       <= '0;
            tbl_cnt     <= '0;
        end else begin
            if (wr_ctrl)   ctrl_q   <= ctrl_t'(reg_wdata);
            if (wr_poly)   poly_q   <= reg_wdata;
            if (wr_cmp)    cmp_q    <= reg_wdata;
            if (wr_reload) reload_q <= reg_wdata;

            if (wr_poly)           tbl_cnt <= TW'(TBL_CYCLES);
            else if (!tbl_done)    tbl_cnt <= tbl_cnt - 1'b1;

            if (wr_cnt) begin
                cnt_q    <= reg_wdata;
                cnt_wr_q <= 1'b1;
            end else if (en_rise) begin
                cnt_q    <= cnt_wr_q ? cnt_q : reload_q;
                loaded_q <= cnt_wr_q ? cnt_q : reload_q;
                cnt_wr_q <= 1'b0;
            end else if (fifo_pop) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (en_rise) res_valid_q <= 1'b0;
            if (expire) begin
                result_q    <= crc_nxt;
                capture_q   <= loaded_q;
                res_valid_q <= 1'b1;
            end

            evt_q <= (evt_q & ~evt_clr) | evt_set;

            if (wr_ien)          ien_q <= {reg_wdata[ST_EXP], reg_wdata[ST_CMP]};
            else if (wr_ien_set) ien_q <= ien_q | {reg_wdata[ST_EXP], reg_wdata[ST_CMP]};
            else if (wr_ien_clr) ien_q <= ien_q & ~{reg_wdata[ST_EXP], reg_wdata[ST_CMP]};
        end
    end

    assign irq = |(evt_q & ien_q);

    logic [31:0] status;
    always_comb begin
        status            = '0;
        status[ST_CMP]    = evt_q[0];
        status[ST_EXP]    = evt_q[1];
        status[ST_INRDY]  = !fifo_full;
        status[ST_OUTRDY] = res_valid_q;
        status[ST_IDLE]   = fifo_empty;
        status[ST_TBL]    = tbl_done;
        status[ST_LVL +: 3] = 3'(fifo_level);
    end

    always_comb begin
        case (reg_addr)
            RG_CTRL:    reg_rdata = ctrl_q;
            RG_POLY:    reg_rdata = poly_q;
            RG_RUN:     reg_rdata = crc_run;
            RG_COUNT:   reg_rdata = cnt_q;
            RG_RELOAD:  reg_rdata = reload_q;
            RG_CAPTURE: reg_rdata = capture_q;
            RG_CMP:     reg_rdata = cmp_q;
            RG_STATUS:  reg_rdata = status;
            RG_IEN:     reg_rdata = {27'b0, ien_q[1], 2'b0, ien_q[0], 1'b0};
            RG_RESULT:  reg_rdata = ctrl_q.res_mir ? rev32(result_q) : result_q;
            RG_REV:     reg_rdata = REVISION;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/crc_regeng_chk.sv
module crc_regeng_chk #(
    parameter int DEPTH = 4,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            s_ready,
    input logic            irq,
    input logic [LVLW-1:0] fifo_level,
    input logic            fifo_pop,
    input logic            tbl_done,
    input logic            poly_we,
    input logic [31:0]     cnt,
    input logic            cnt_load,
    input logic [1:0]      evt
);
    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVLW'(DEPTH));

    // R11
    stream_ready_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (fifo_level < LVLW'(DEPTH)));

    // R9
    tbl_clear_chk: assert property (@(posedge clk) disable iff (rst)
        poly_we |=> !tbl_done);

    // R9
    pop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> tbl_done);

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_load |=> (cnt == $past(cnt) || cnt == $past(cnt) - 32'd1));

    // R12
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (evt != 2'b00));
endmodule

bind crc_regeng crc_regeng_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .s_ready(s_ready), .irq(irq),
    .fifo_level(fifo_level), .fifo_pop(fifo_pop), .tbl_done(tbl_done),
    .poly_we(wr_poly), .cnt(cnt_q), .cnt_load(wr_cnt || en_rise), .evt(evt_q)
);

// File: tb/crc_regeng_bench.sv
module crc_regeng_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] POLY = 32'h04C1_1DB7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_ready;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    crc_regeng u_crc_regeng (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] brev(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] mir(input logic [31:0] v, input logic [2:0] m);
        logic [31:0] r;
        r = v;
        if (m[0]) for (int b = 0; b < 4; b++) for (int i = 0; i < 8; i++) r[8*b+i] = v[8*b+7-i];
        if (m[1]) r = {r[7:0], r[15:8], r[23:16], r[31:24]};
        if (m[2]) r = {r[15:0], r[31:16]};
        return r;
    endfunction

    function automatic logic [31:0] crc1(input logic [31:0] c, input logic [31:0] d,
                                         input logic [31:0] p);
        logic [31:0] x;
        x = c;
        for (int i = 31; i >= 0; i--) begin
            if (x[31] ^ d[i]) x = (x << 1) ^ p;
            else              x = x << 1;
        end
        return x;
    endfunction

    function automatic logic [31:0] wgen(input int k);
        return (32'h9E37_79B9 * (k + 1)) ^ (32'h0000_5A00 + k);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, e, run, ctl, cmpv, pe;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(4'd8, v);  chk("R1 status", v, 32'h000D_0000);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        rd(4'd13, v); chk("R1 revision", v, 32'h0001_0300);

        // R2 R3 R5 R6 R8 sweep
        for (int m = 0; m < 8; m++) begin
            for (int pm = 0; pm < 2; pm++) begin
                for (int n = 1; n <= 3; n++) begin
                    logic rm, cm;
                    rm = m[0] ^ pm[0];
                    cm = (n == 2);
                    pe = pm[0] ? brev(POLY) : POLY;
                    run = 32'hFFFF_FFFF ^ (m * 32'h0101_0101);
                    e = run;
                    for (int k = 0; k < n; k++) e = crc1(e, mir(wgen(k + m), m[2:0]), pe);
                    cmpv = cm ? brev(e) : e;
                    if (m == 6) cmpv = cmpv ^ 32'h10;
                    wr(4'd0, 32'd0);
                    wr(4'd1, POLY);
                    idle(10);
                    wr(4'd2, run);
                    wr(4'd6, cmpv);
                    wr(4'd3, n);
                    for (int k = 0; k < n; k++) wr(4'd7, wgen(k + m));
                    ctl = 32'h31 | (m[0] << 16) | (m[1] << 17) | (m[2] << 18)
                          | (32'(rm) << 20) | (pm << 21) | (32'(cm) << 22);
                    wr(4'd0, ctl);
                    idle(6);
                    rd(4'd2, v);  chk("R2 running value", v, e);
                    rd(4'd12, v); chk("R5 R3 final result", v, rm ? brev(e) : e);
                    rd(4'd8, v);
                    chk("R6 expiry bit", {31'b0, v[4]}, 32'd1);
                    chk("R8 compare error bit", {31'b0, v[1]}, {31'b0, (m == 6)});
                    rd(4'd5, v);  chk("R6 capture", v, n);
                    wr(4'd8, 32'h12);
                end
            end
        end

        // R7 reload on enable, R6 stop at zero
        wr(4'd0, 32'd0);
        wr(4'd4, 32'd2);
        wr(4'd2, 32'd0);
        for (int k = 0; k < 3; k++) wr(4'd7, wgen(40 + k));
        wr(4'd0, 32'h31);
        idle(6);
        e = crc1(crc1(32'd0, wgen(40), POLY), wgen(41), POLY);
        rd(4'd8, v);  chk("R6 stop leaves one word", {29'b0, v[22:20]}, 32'd1);
        rd(4'd5, v);  chk("R7 reload captured", v, 32'd2);
        rd(4'd2, v);  chk("R7 two words", v, e);
        wr(4'd0, 32'd0);
        wr(4'd3, 32'd1);
        wr(4'd0, 32'h31);
        idle(6);
        e = crc1(e, wgen(42), POLY);
        rd(4'd5, v);  chk("R7 direct count kept", v, 32'd1);
        rd(4'd2, v);  chk("R7 third word", v, e);
        rd(4'd8, v);  chk("R6 drained", {29'b0, v[22:20]}, 32'd0);
        wr(4'd8, 32'h12);

        // R4 mirror at FIFO entry versus at consumption
        for (int f = 0; f < 2; f++) begin
            wr(4'd0, 32'd0);
            wr(4'd2, 32'd0);
            wr(4'd3, 32'd1);
            wr(4'd0, 32'h0001_0000 | (f << 19));
            wr(4'd7, 32'h1234_5678);
            wr(4'd0, 32'h31 | (f << 19));
            idle(6);
            e = crc1(32'd0, f ? mir(32'h1234_5678, 3'b001) : 32'h1234_5678, POLY);
            rd(4'd2, v); chk("R4 mirror timing", v, e);
            wr(4'd8, 32'h12);
        end

        // R9 preparation stall
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd0);
        wr(4'd3, 32'd1);
        wr(4'd0, 32'h31);
        wr(4'd1, POLY);
        rd(4'd8, v); chk("R9 table busy", {31'b0, v[19]}, 32'd0);
        wr(4'd7, 32'hCAFE_F00D);
        rd(4'd8, v); chk("R9 word held", {29'b0, v[22:20]}, 32'd1);
        idle(10);
        rd(4'd8, v);
        chk("R9 table done", {31'b0, v[19]}, 32'd1);
        chk("R9 word consumed", {29'b0, v[22:20]}, 32'd0);
        rd(4'd2, v); chk("R9 result", v, crc1(32'd0, 32'hCAFE_F00D, POLY));
        wr(4'd8, 32'h12);

        // R13 unsupported mode
        wr(4'd0, 32'd0);
        wr(4'd3, 32'd1);
        wr(4'd0, 32'h11);
        wr(4'd7, 32'h0BAD_0BAD);
        idle(4);
        rd(4'd8, v);
        chk("R13 no consume", {29'b0, v[22:20]}, 32'd1);
        chk("R13 no expiry", {31'b0, v[4]}, 32'd0);
        // drain it in stream mode
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd0);
        wr(4'd0, 32'h31);
        idle(4);
        wr(4'd8, 32'h12);

        // R10 full FIFO drops
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd0);
        for (int k = 0; k < 5; k++) wr(4'd7, wgen(60 + k));
        rd(4'd8, v);
        chk("R10 level full", {29'b0, v[22:20]}, 32'd4);
        chk("R10 not-full bit", {31'b0, v[16]}, 32'd0);
        chk("R11 ready low when full", {31'b0, s_ready}, 32'd0);
        wr(4'd3, 32'd4);
        wr(4'd0, 32'h31);
        idle(8);
        e = 32'd0;
        for (int k = 0; k < 4; k++) e = crc1(e, wgen(60 + k), POLY);
        rd(4'd2, v); chk("R10 fifth word dropped", v, e);
        wr(4'd8, 32'h12);

        // R11 stream port and register priority
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd7);
        wr(4'd3, 32'd6);
        @(negedge clk);
        s_valid = 1'b1; reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = wgen(70);
        #1 chk("R11 register write priority", {31'b0, s_ready}, 32'd0);
        @(negedge clk);
        reg_wr = 1'b0; s_valid = 1'b0;
        wr(4'd0, 32'h31);
        for (int k = 1; k < 6; k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = wgen(70 + k);
            #1;
            while (!s_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk) s_valid = 1'b0;
        idle(6);
        e = 32'd7;
        for (int k = 0; k < 6; k++) e = crc1(e, wgen(70 + k), POLY);
        rd(4'd2, v); chk("R11 stream result", v, e);

        // R12 interrupt enables (expiry event still pending)
        chk("R12 irq masked", {31'b0, irq}, 32'd0);
        wr(4'd10, 32'h10);
        rd(4'd9, v); chk("R12 enable readback", v, 32'h10);
        chk("R12 irq on", {31'b0, irq}, 32'd1);
        wr(4'd11, 32'h10);
        chk("R12 irq cleared enable", {31'b0, irq}, 32'd0);
        wr(4'd10, 32'h10);
        wr(4'd8, 32'h10);
        chk("R12 irq after w1c", {31'b0, irq}, 32'd0);
        rd(4'd8, v); chk("R12 event cleared", {31'b0, v[4]}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule